// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single load-reserved reservation of one processor core and decides the outcome of every store-conditional. A load-reserved records the cache line that holds its address and arms the reservation. A later store-conditional succeeds only while that reservation is still armed and covers the same line. Success returns a zero code. Failure returns one of two nonzero codes. Every store-conditional disarms the reservation. A taken interrupt or trap disarms it as well.

The monitor also sits on the coherence side of the core. The interconnect raises a probe request with an address and holds it until the monitor pulses an acknowledge. A probe for any line other than the reserved one is acknowledged after a single cycle. A probe for the reserved line is held back for a bounded number of cycles. This gives a short reservation sequence within one line time to reach its store-conditional. When the sequence ends, the held probe is released on the following cycle. When the window runs out first, the probe is released and the reservation is dropped.

Top module: `lrsc_resv_monitor`

## Requirements
- R1: A load-reserved arms a reservation on the line of its address, where the line is the address with its low log2(LINE_BYTES) bits dropped (6 bits by default). A store-conditional to any address in that line while the reservation is armed returns code 0.
- R2: Each store-conditional gets `sc_done` high for exactly the one cycle after the edge that samples it. The code is 1 when no reservation is armed and 2 when the reservation is armed on another line. Every store-conditional disarms the reservation.
- R3: A new load-reserved replaces any armed reservation, so a store-conditional to the old line then returns code 2.
- R4: `trap` disarms the reservation. A `trap` sampled on the same edge as a store-conditional makes that store-conditional return code 1.
- R5: A probe whose line is not the armed reservation's line gets `prb_ack` high in the cycle right after the edge that accepts it, and the reservation is left intact.
- R6: A probe for the armed line is accepted at edge E0 and is acknowledged no later than the cycle after edge E0+HOLD_MAX (16 by default). At that expiry edge the reservation is disarmed, and a store-conditional sampled on that same edge still succeeds.
- R7: If the reservation ends during the hold window at edge E0+j, with j at most HOLD_MAX-1, the probe is acknowledged in the cycle after edge E0+j+1. The reservation can end through a store-conditional, a trap or a replacing load-reserved. For j = 0, the reservation ends on the accepting edge itself.
- R8: A load-reserved sampled on the edge where a probe for its own line is released is not recorded. A later store-conditional to that line returns code 1.
- R9: Synchronous active-high `rst` disarms the reservation and ends any hold. After reset, `prb_ack` and `sc_done` are low, and a fresh probe gets the full window again.
- R10: `prb_ack` is a one-cycle pulse. A request still high at the edge that ends the acknowledge cycle is ignored. The requester must drop `prb_req` during the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserved issued this cycle |
| lr_addr | input | ADDR_W | Load-reserved byte address |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| trap | input | 1 | Interrupt or trap taken this cycle |
| sc_done | output | 1 | Store-conditional result valid |
| sc_code | output | 2 | 0 success, 1 no reservation, 2 wrong line |
| prb_req | input | 1 | Coherence probe request, held until acknowledged |
| prb_addr | input | ADDR_W | Probe byte address |
| prb_ack | output | 1 | One-cycle probe acknowledge |

## Verification
The assertions check several rules on every cycle. Each store-conditional gets exactly one response a cycle later and leaves the reservation disarmed. A trap always disarms it. A success code never appears without an armed reservation on the matching line. A probe for an unreserved line is acknowledged at once, the acknowledge never lasts two cycles, and a hold never outlives its window. Some behaviour needs exact cycle placement, and only the bench's scenarios can show it. This covers the sweep of store-conditional and trap positions across the whole window, the acknowledge edge relative to the response, success on the expiry edge itself, the dropped load-reserved on a release edge, and a request ignored during the acknowledge cycle.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int ADDR_W_DEF     = 32;
    localparam int LINE_BYTES_DEF = 64;
    localparam int HOLD_MAX_DEF   = 16;

    typedef enum logic [1:0] {
        SC_OK         = 2'd0,
        SC_NO_RESV    = 2'd1,
        SC_WRONG_LINE = 2'd2
    } sc_code_e;

    typedef enum logic [1:0] {
        PRB_IDLE = 2'd0,
        PRB_HOLD = 2'd1,
        PRB_ACK  = 2'd2
    } prb_state_e;

    // Outcome of a store-conditional against the current reservation.
    function automatic sc_code_e sc_judge(input logic armed, input logic same_line);
        if (!armed)
            return SC_NO_RESV;
        else if (!same_line)
            return SC_WRONG_LINE;
        else
            return SC_OK;
    endfunction

endpackage

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [LINE_W-1:0] take_line,
    input  logic              drop,
    output logic              armed,
    output logic [LINE_W-1:0] line
);

    typedef struct packed {
        logic              armed;
        logic [LINE_W-1:0] line;
    } resv_t;

    resv_t cur_q;
    resv_t cur_n;

    always_comb begin
        cur_n = cur_q;
        if (take) begin
            cur_n.armed = 1'b1;
            cur_n.line  = take_line;
        end else if (drop) begin
            cur_n.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_n;
        end
    end

    assign armed = cur_q.armed;
    assign line  = cur_q.line;

endmodule

// File: rtl/lrsc_sc_resp.sv
module lrsc_sc_resp
    import lrsc_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sc_req,
    input  logic [LINE_W-1:0] sc_line,
    input  logic              armed,
    input  logic [LINE_W-1:0] resv_line,
    output logic              done,
    output sc_code_e          code
);

    sc_code_e code_n;

    always_comb begin
        code_n = sc_judge(armed, resv_line == sc_line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            code <= SC_NO_RESV;
        end else begin
            done <= sc_req;
            if (sc_req) begin
                code <= code_n;
            end
        end
    end

endmodule

// File: rtl/lrsc_probe_ctrl.sv
module lrsc_probe_ctrl
    import lrsc_pkg::*;
#(
    parameter int LINE_W   = 26,
    parameter int HOLD_MAX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [LINE_W-1:0] req_line,
    input  logic              armed,
    input  logic [LINE_W-1:0] resv_line,
    output logic              ack,
    output logic              holding,
    output logic              expire,
    output logic              rel_now,
    output logic [LINE_W-1:0] rel_line
);

    localparam int CNT_W = $clog2(HOLD_MAX + 1);

    prb_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [LINE_W-1:0] held_q, held_n;
    logic              hit_new, hit_held;

    assign hit_new  = armed && (resv_line == req_line);
    assign hit_held = armed && (resv_line == held_q);

    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        held_n   = held_q;
        rel_now  = 1'b0;
        expire   = 1'b0;
        rel_line = held_q;
        unique case (state_q)
            PRB_IDLE: begin
                if (req) begin
                    held_n = req_line;
                    if (hit_new) begin
                        state_n = PRB_HOLD;
                        cnt_n   = CNT_W'(1);
                    end else begin
                        state_n  = PRB_ACK;
                        rel_now  = 1'b1;
                        rel_line = req_line;
                    end
                end
            end
            PRB_HOLD: begin
                if (!hit_held) begin
                    state_n = PRB_ACK;
                    rel_now = 1'b1;
                end else if (cnt_q == CNT_W'(HOLD_MAX)) begin
                    state_n = PRB_ACK;
                    rel_now = 1'b1;
                    expire  = 1'b1;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            PRB_ACK: begin
                state_n = PRB_IDLE;
            end
            default: begin
                state_n = PRB_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PRB_IDLE;
            cnt_q   <= '0;
            held_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            held_q  <= held_n;
        end
    end

    assign ack     = (state_q == PRB_ACK);
    assign holding = (state_q == PRB_HOLD);

endmodule

// File: rtl/lrsc_resv_monitor.sv
module lrsc_resv_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int LINE_BYTES = LINE_BYTES_DEF,
    parameter int HOLD_MAX   = HOLD_MAX_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_valid,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              trap,
    output logic              sc_done,
    output logic [1:0]        sc_code,
    input  logic              prb_req,
    input  logic [ADDR_W-1:0] prb_addr,
    output logic              prb_ack
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] lr_line, sc_line, prb_line;
    logic              resv_valid;
    logic [LINE_W-1:0] resv_line;
    logic              holding, expire, rel_now;
    logic [LINE_W-1:0] rel_line;
    logic              lr_take, resv_drop;
    sc_code_e          code_e;

    assign lr_line  = lr_addr[ADDR_W-1:OFF_W];
    assign sc_line  = sc_addr[ADDR_W-1:OFF_W];
    assign prb_line = prb_addr[ADDR_W-1:OFF_W];

    // A load-reserved loses against a trap and against the release of its own line.
    assign lr_take   = lr_valid && !trap && !(rel_now && (rel_line == lr_line));
    assign resv_drop = sc_valid || trap || expire;

    lrsc_resv_reg #(
        .LINE_W(LINE_W)
    ) resv_i (
        .clk      (clk),
        .rst      (rst),
        .take     (lr_take),
        .take_line(lr_line),
        .drop     (resv_drop),
        .armed    (resv_valid),
        .line     (resv_line)
    );

    lrsc_sc_resp #(
        .LINE_W(LINE_W)
    ) sc_i (
        .clk      (clk),
        .rst      (rst),
        .sc_req   (sc_valid),
        .sc_line  (sc_line),
        .armed    (resv_valid && !trap),
        .resv_line(resv_line),
        .done     (sc_done),
        .code     (code_e)
    );

    lrsc_probe_ctrl #(
        .LINE_W  (LINE_W),
        .HOLD_MAX(HOLD_MAX)
    ) prb_i (
        .clk      (clk),
        .rst      (rst),
        .req      (prb_req),
        .req_line (prb_line),
        .armed    (resv_valid),
        .resv_line(resv_line),
        .ack      (prb_ack),
        .holding  (holding),
        .expire   (expire),
        .rel_now  (rel_now),
        .rel_line (rel_line)
    );

    assign sc_code = code_e;

endmodule

// File: rtl/lrsc_resv_monitor_chk.sv
module lrsc_resv_monitor_chk #(
    parameter int ADDR_W   = 32,
    parameter int LINE_W   = 26,
    parameter int HOLD_MAX = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lr_valid,
    input logic              sc_valid,
    input logic [LINE_W-1:0] sc_line,
    input logic [LINE_W-1:0] prb_line,
    input logic              trap,
    input logic              sc_done,
    input logic [1:0]        sc_code,
    input logic              prb_req,
    input logic              prb_ack,
    input logic              resv_valid,
    input logic [LINE_W-1:0] resv_line,
    input logic              holding
);

    localparam int RUN_W = $clog2(HOLD_MAX + 2) + 1;

    logic [RUN_W-1:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_run <= '0;
        end else if (holding) begin
            hold_run <= hold_run + RUN_W'(1);
        end else begin
            hold_run <= '0;
        end
    end

    // R2: response one cycle after each request, and only then
    p_sc_resp_r2: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> sc_done);
    p_sc_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |=> !sc_done);
    // R2: store-conditional always disarms
    p_sc_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !lr_valid) |=> !resv_valid);
    // R1: success only with an armed reservation on the same line
    p_sc_ok_r1: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !(resv_valid && resv_line == sc_line)) |=> (sc_code != 2'd0));
    // R4: trap disarms
    p_trap_clears_r4: assert property (@(posedge clk) disable iff (rst)
        trap |=> !resv_valid);
    // R5: unreserved line acknowledged at once
    p_fast_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (prb_req && !prb_ack && !holding && !(resv_valid && resv_line == prb_line))
        |=> prb_ack);
    // R10: acknowledge lasts one cycle
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        prb_ack |=> !prb_ack);
    // R6: hold never outlives its window
    p_hold_bound_r6: assert property (@(posedge clk) disable iff (rst)
        holding |-> (hold_run < RUN_W'(HOLD_MAX)));

endmodule

bind lrsc_resv_monitor lrsc_resv_monitor_chk #(
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W),
    .HOLD_MAX(HOLD_MAX)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .lr_valid  (lr_valid),
    .sc_valid  (sc_valid),
    .sc_line   (sc_line),
    .prb_line  (prb_line),
    .trap      (trap),
    .sc_done   (sc_done),
    .sc_code   (sc_code),
    .prb_req   (prb_req),
    .prb_ack   (prb_ack),
    .resv_valid(resv_valid),
    .resv_line (resv_line),
    .holding   (holding)
);

// File: tb/lrsc_resv_monitor_tb_top.sv
module lrsc_resv_monitor_tb_top;

    localparam int AW   = 32;
    localparam int HOLD = 16;

    localparam logic [AW-1:0] ADDR_A    = 32'h0000_1040;
    localparam logic [AW-1:0] ADDR_A2   = 32'h0000_1078;
    localparam logic [AW-1:0] ADDR_B    = 32'h0000_2000;

    logic          clk = 1'b0;
    logic          rst;
    logic          lr_valid, sc_valid, trap, prb_req;
    logic [AW-1:0] lr_addr, sc_addr, prb_addr;
    logic          sc_done, prb_ack;
    logic [1:0]    sc_code;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lrsc_resv_monitor dut_i (
        .clk     (clk),
        .rst     (rst),
        .lr_valid(lr_valid),
        .lr_addr (lr_addr),
        .sc_valid(sc_valid),
        .sc_addr (sc_addr),
        .trap    (trap),
        .sc_done (sc_done),
        .sc_code (sc_code),
        .prb_req (prb_req),
        .prb_addr(prb_addr),
        .prb_ack (prb_ack)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        lr_valid = 0; sc_valid = 0; trap = 0; prb_req = 0;
        lr_addr = '0; sc_addr = '0; prb_addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_in();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_lr(input logic [AW-1:0] a);
        lr_valid = 1'b1; lr_addr = a;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    task automatic do_sc(input logic [AW-1:0] a, input int exp, input string tag);
        sc_valid = 1'b1; sc_addr = a;
        @(negedge clk);
        sc_valid = 1'b0;
        check({tag, " done"}, int'(sc_done), 1);
        check({tag, " code"}, int'(sc_code), exp);
        @(negedge clk);
        check({tag, " done drops"}, int'(sc_done), 0);
    endtask

    // Probe with a reservation on ADDR_A; end event (SC or trap) at edge E0+j.
    task automatic hold_case(input int j, input bit use_trap, input string tag);
        int ack_at, ack_cnt, sc_at, sc_got;
        int exp_ack;
        ack_at = -1; ack_cnt = 0; sc_at = -1; sc_got = -1;
        do_lr(ADDR_A);
        prb_req = 1'b1; prb_addr = ADDR_A2;
        if (use_trap) trap = (j == 0); else begin sc_valid = (j == 0); sc_addr = ADDR_A; end
        for (int t = 0; t <= 24; t++) begin
            @(negedge clk);
            if (prb_ack) begin
                ack_cnt++;
                if (ack_at < 0) ack_at = t;
                prb_req = 1'b0;
            end
            if (sc_done) begin sc_at = t; sc_got = int'(sc_code); end
            if (use_trap) trap = (t == j - 1);
            else sc_valid = (t == j - 1);
        end
        exp_ack = (j <= HOLD - 1) ? j + 1 : HOLD;
        check({tag, " ack edge"}, ack_at, exp_ack);
        check({tag, " ack pulses"}, ack_cnt, 1);
        if (!use_trap) begin
            check({tag, " sc edge"}, sc_at, j);
            check({tag, " sc code"}, sc_got, (j <= HOLD) ? 0 : 1);
        end else begin
            do_sc(ADDR_A, 1, {tag, " sc after trap"});
        end
    endtask

    // Probe accepted at E0; returns index of first ack observation.
    task automatic quick_probe(input logic [AW-1:0] a, output int ack_at);
        ack_at = -1;
        prb_req = 1'b1; prb_addr = a;
        for (int t = 0; t <= 20; t++) begin
            @(negedge clk);
            if (prb_ack && ack_at < 0) begin
                ack_at = t;
                prb_req = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int a;
        rst = 1'b1;
        idle_in();
        do_reset();

        // R9: reset state
        check("R9 ack after reset", int'(prb_ack), 0);
        check("R9 done after reset", int'(sc_done), 0);
        do_sc(ADDR_A, 1, "R9 sc after reset");

        // R1: same-line success, any offset
        do_lr(ADDR_A);
        do_sc(ADDR_A2, 0, "R1 same line other offset");
        // R2: always clears, wrong line code
        do_sc(ADDR_A, 1, "R2 second sc");
        do_lr(ADDR_A);
        do_sc(ADDR_B, 2, "R2 wrong line");
        do_sc(ADDR_A, 1, "R2 cleared by failing sc");

        // R3: replacement
        do_lr(ADDR_A);
        do_lr(ADDR_B);
        do_sc(ADDR_A, 2, "R3 old line");
        do_lr(ADDR_A);
        do_lr(ADDR_B);
        do_sc(ADDR_B, 0, "R3 new line");

        // R4: trap before and with SC
        do_lr(ADDR_A);
        trap = 1'b1; @(negedge clk); trap = 1'b0;
        do_sc(ADDR_A, 1, "R4 trap before sc");
        do_lr(ADDR_A);
        trap = 1'b1;
        do_sc(ADDR_A, 1, "R4 trap with sc");
        trap = 1'b0;

        // R5: no reservation, and reservation on another line left intact
        quick_probe(ADDR_A, a);
        check("R5 ack no resv", a, 0);
        do_lr(ADDR_B);
        quick_probe(ADDR_A, a);
        check("R5 ack other line", a, 0);
        do_sc(ADDR_B, 0, "R5 resv intact");

        // R6, R7: sweep SC position across the window
        for (int j = 0; j <= 20; j++) begin
            hold_case(j, 1'b0, $sformatf("R6 R7 sc j=%0d", j));
        end
        // R7, R4: trap positions
        hold_case(0, 1'b1, "R7 trap j=0");
        hold_case(5, 1'b1, "R7 trap j=5");
        hold_case(15, 1'b1, "R7 trap j=15");
        hold_case(16, 1'b1, "R6 trap j=16");
        hold_case(18, 1'b1, "R6 trap j=18");

        // R6: expiry without SC drops the reservation
        do_lr(ADDR_A);
        quick_probe(ADDR_A, a);
        check("R6 expiry ack", a, HOLD);
        do_sc(ADDR_A, 1, "R6 resv dropped at expiry");

        // R8: LR to the line released on the same edge
        prb_req = 1'b1; prb_addr = ADDR_A;
        lr_valid = 1'b1; lr_addr = ADDR_A2;
        @(negedge clk);
        lr_valid = 1'b0;
        check("R8 ack", int'(prb_ack), 1);
        prb_req = 1'b0;
        @(negedge clk);
        do_sc(ADDR_A, 1, "R8 lr not recorded");

        // R10: request left high through the ack cycle is ignored
        prb_req = 1'b1; prb_addr = ADDR_B;
        @(negedge clk);
        check("R10 ack first", int'(prb_ack), 1);
        @(negedge clk);
        check("R10 ignored in ack cycle", int'(prb_ack), 0);
        prb_req = 1'b0;
        @(negedge clk);
        check("R10 no second ack", int'(prb_ack), 0);

        // R9: reset in the middle of a hold
        do_lr(ADDR_A);
        prb_req = 1'b1; prb_addr = ADDR_A;
        repeat (5) @(negedge clk);
        rst = 1'b1; prb_req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R9 ack after mid-hold reset", int'(prb_ack), 0);
        do_sc(ADDR_A, 1, "R9 resv cleared by reset");
        do_lr(ADDR_A);
        quick_probe(ADDR_A, a);
        check("R9 full window after reset", a, HOLD);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule